// File: doc/BRIEF.md
# Fixed-Priority Edge-Triggered Interrupt Resolver

The resolver watches the interrupt request lines that arrive from an expansion channel. It brings each line into the local clock domain and turns each low-to-high transition into a pending request. Among all pending requests it chooses one winner by a fixed order that does not follow the line numbers: lines 9 to 12 and 14 to 15 outrank lines 3 to 7. Line 9 is served first and line 7 last. The winner goes to the processor side as a 4-bit line number with a valid flag.

Lines 0 to 2, 8 and 13 belong to logic on the board and are never taken from the channel. The processor accepts the presented request with a valid/ready handshake. Acceptance retires that one request, and the next winner is presented on the following clock.

Back-pressure rules: while `grant_ready` is low, the presented number stays put. It changes only if a higher-ranked request arrives, or if the presented line drops and withdraws its request. A transfer happens on any clock edge where `grant_valid` and `grant_ready` are both high. `grant_ready` may be held high to drain every pending request, one per clock.

Top module: `irq_edge_resolver`

## Requirements
- R1: When several requests are pending, `grant_num` shows the one ranked highest in the order 9, 10, 11, 12, 14, 15, 3, 4, 5, 6, 7. A newly pending request of higher rank replaces the presented one.
- R2: A request becomes pending only on a low-to-high transition of its synchronised line. A line that stays high after its request was accepted raises no new request until it falls and rises again.
- R3: If a line falls low before its request is accepted, the request is withdrawn. Three rising clock edges after the fall, it is no longer presented.
- R4: A transfer (`grant_valid` and `grant_ready` high at an edge) clears only the request whose number is presented. Every other pending request is kept.
- R5: Transitions on lines 0, 1, 2, 8 and 13 never produce a request.
- R6: `grant_valid` is low whenever nothing is pending. `grant_num` is 0 while `grant_valid` is low.
- R7: With the default two-stage synchroniser, a rising line is first presented after the third rising clock edge that follows the change.
- R8: Without a transfer, a new request or a withdrawal, `grant_valid` and `grant_num` hold their values. After a transfer, the next winner appears on the very next edge.
- R9: While `rst_n` is low, `grant_valid` is low and no request is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| chan_irq | input | 16 | Raw channel request lines; bit n is line n |
| grant_valid | output | 1 | A request is presented |
| grant_ready | input | 1 | Processor accepts the presented request |
| grant_num | output | 4 | Number of the presented line |

## Verification
The bench builds the resolver with its defaults: sixteen lines, a two-stage synchroniser, the accept mask that excludes lines 0 to 2, 8 and 13, and line 9 as the top of the rotation. This makes the exact three-edge latency and the full eleven-entry drain order checkable cycle by cycle. A reference model rebuilds the pending set from the delayed line history on every clock. It is driven by directed scenarios for preemption, withdrawal, re-arming after acceptance and ignored board lines, and then by a long random mix of line toggles and ready stalls.

// File: rtl/irq_res_pkg.sv
package irq_res_pkg;
  // Default geometry of the channel request set
  localparam int unsigned DEF_LINES      = 16;
  // Lines 3-7, 9-12, 14, 15 are taken from the channel
  localparam logic [15:0] DEF_ACCEPT     = 16'hDEF8;
  // Line that heads the fixed rotation; higher numbers follow, then wrap to 0
  localparam int unsigned DEF_TOP_LINE   = 9;
  localparam int unsigned DEF_SYNC_DEPTH = 2;

  typedef enum logic {GRANT_IDLE = 1'b0, GRANT_SHOWN = 1'b1} grant_state_e;
endpackage

// File: rtl/irq_line_sync.sv
module irq_line_sync #(
  parameter int unsigned N      = 16,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] raw_in,
  output logic [N-1:0] sync_out
);
  logic [N-1:0] chain [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[0] <= '0;
        else        chain[0] <= raw_in;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[s] <= '0;
        else        chain[s] <= chain[s-1];
      end
    end
  end

  assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/irq_pend_bank.sv
module irq_pend_bank #(
  parameter int unsigned  N    = 16,
  parameter logic [N-1:0] MASK = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] line_sync,
  input  logic [N-1:0] retire,
  output logic [N-1:0] rise,
  output logic [N-1:0] pend_q,
  output logic [N-1:0] pend_nx
);
  logic [N-1:0] line_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) line_prev <= '0;
    else        line_prev <= line_sync;
  end

  assign rise = line_sync & ~line_prev & MASK;

  // A request lives while its line stays high and it has not been retired
  assign pend_nx = (pend_q | rise) & line_sync & MASK & ~retire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_nx;
  end
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int unsigned N   = 16,
  parameter int unsigned TOP = 9,
  localparam int unsigned IW = $clog2(N)
) (
  input  logic [N-1:0]  req,
  output logic          any,
  output logic [IW-1:0] win
);
  logic [N-1:0]  rot;
  logic [IW-1:0] pos;

  // rot[0] is the highest ranked line, rot[N-1] the lowest
  for (genvar k = 0; k < N; k++) begin : g_rot
    assign rot[k] = req[(TOP + k) % N];
  end

  always_comb begin
    pos = '0;
    for (int k = N - 1; k >= 0; k--) begin
      if (rot[k]) pos = IW'(k);
    end
  end

  assign any = |rot;
  assign win = IW'((int'(pos) + int'(TOP)) % int'(N));
endmodule

// File: rtl/irq_edge_resolver.sv
module irq_edge_resolver
  import irq_res_pkg::*;
#(
  parameter int unsigned  LINES       = DEF_LINES,
  parameter int unsigned  SYNC_DEPTH  = DEF_SYNC_DEPTH,
  parameter int unsigned  TOP_LINE    = DEF_TOP_LINE,
  parameter logic [LINES-1:0] ACCEPT_MASK = LINES'(DEF_ACCEPT),
  localparam int unsigned NUM_W       = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] chan_irq,
  output logic             grant_valid,
  input  logic             grant_ready,
  output logic [NUM_W-1:0] grant_num
);
  logic [LINES-1:0] sync_w;
  logic [LINES-1:0] rise_w;
  logic [LINES-1:0] pend_q;
  logic [LINES-1:0] pend_nx;
  logic [LINES-1:0] retire_w;
  logic             pick_any;
  logic [NUM_W-1:0] pick_num;
  grant_state_e     gstate;

  irq_line_sync #(.N(LINES), .STAGES(SYNC_DEPTH)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .raw_in   (chan_irq),
    .sync_out (sync_w)
  );

  // A transfer retires exactly the presented line
  assign retire_w = (grant_valid && grant_ready) ? (LINES'(1) << grant_num) : '0;

  irq_pend_bank #(.N(LINES), .MASK(ACCEPT_MASK)) u_pend (
    .clk       (clk),
    .rst_n     (rst_n),
    .line_sync (sync_w),
    .retire    (retire_w),
    .rise      (rise_w),
    .pend_q    (pend_q),
    .pend_nx   (pend_nx)
  );

  // Resolve on the next pending set so the following winner shows one edge after a transfer
  irq_prio_pick #(.N(LINES), .TOP(TOP_LINE)) u_pick (
    .req (pend_nx),
    .any (pick_any),
    .win (pick_num)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gstate    <= GRANT_IDLE;
      grant_num <= '0;
    end else begin
      gstate    <= pick_any ? GRANT_SHOWN : GRANT_IDLE;
      grant_num <= pick_any ? pick_num : '0;
    end
  end

  assign grant_valid = (gstate == GRANT_SHOWN);
endmodule

// File: rtl/irq_resolver_chk.sv
module irq_resolver_chk #(
  parameter int unsigned  N    = 16,
  parameter logic [N-1:0] MASK = '1,
  localparam int unsigned IW   = $clog2(N)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          grant_valid,
  input logic          grant_ready,
  input logic [IW-1:0] grant_num,
  input logic [N-1:0]  line_sync,
  input logic [N-1:0]  pend_q,
  input logic [N-1:0]  rise_vec
);
  // R5
  board_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid |-> MASK[grant_num]);

  // R6
  idle_num_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !grant_valid |-> grant_num == '0);

  // R4
  retire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_valid && grant_ready) |=> !(grant_valid && grant_num == $past(grant_num)));

  // R8
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!grant_ready && rise_vec == '0 && (pend_q & ~line_sync) == '0)
      |=> ($stable(grant_valid) && $stable(grant_num)));

  // R3
  withdraw_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend_q & ~$past(line_sync)) == '0));

  // R2
  edge_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend_q & ~$past(pend_q) & ~$past(rise_vec)) == '0));

  // R9
  reset_idle_chk: assert property (@(posedge clk)
    !rst_n |-> (!grant_valid && pend_q == '0));
endmodule

bind irq_edge_resolver irq_resolver_chk #(.N(LINES), .MASK(ACCEPT_MASK)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .grant_valid (grant_valid),
  .grant_ready (grant_ready),
  .grant_num   (grant_num),
  .line_sync   (sync_w),
  .pend_q      (pend_q),
  .rise_vec    (rise_w)
);

// File: tb/irq_edge_resolver_test.sv
module irq_edge_resolver_test;
  localparam int CLK_PERIOD = 10;
  localparam int SYNC = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] chan_irq = '0;
  logic        grant_ready = 1'b0;
  logic        grant_valid;
  logic [3:0]  grant_num;

  int checks = 0;
  int errors = 0;
  string cur_req = "R9";

  irq_edge_resolver uut (
    .clk(clk), .rst_n(rst_n), .chan_irq(chan_irq),
    .grant_valid(grant_valid), .grant_ready(grant_ready), .grant_num(grant_num)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Reference model
  int order [11] = '{9, 10, 11, 12, 14, 15, 3, 4, 5, 6, 7};
  logic [15:0] hist [$];
  bit   [15:0] m_pend;
  bit          exp_valid;
  int          exp_num;

  function automatic bit accepted(int n);
    foreach (order[i]) if (order[i] == n) return 1'b1;
    return 1'b0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      hist = {};
      for (int i = 0; i <= SYNC; i++) hist.push_back(16'h0);
      m_pend = '0; exp_valid = 1'b0; exp_num = 0;
    end else begin
      logic [15:0] s_now, s_old;
      bit took;
      s_now = hist[SYNC-1];
      s_old = hist[SYNC];
      took  = exp_valid && grant_ready;
      for (int n = 0; n < 16; n++) begin
        bit p;
        p = accepted(n) && s_now[n] && (m_pend[n] || !s_old[n]);
        if (took && n == exp_num) p = 1'b0;
        m_pend[n] = p;
      end
      exp_valid = 1'b0; exp_num = 0;
      foreach (order[i]) begin
        if (!exp_valid && m_pend[order[i]]) begin
          exp_valid = 1'b1; exp_num = order[i];
        end
      end
      hist.push_front(chan_irq);
      void'(hist.pop_back());
    end
  end

  task automatic check(bit ok, string tag, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s at %0t: actual %0d expected %0d", tag, $time, act, expv);
    end
  endtask

  // Cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      check(grant_valid == exp_valid, {cur_req, " valid"}, int'(grant_valid), int'(exp_valid));
      check(grant_num == 4'(exp_num), {cur_req, " num"}, int'(grant_num), exp_num);
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    tick(4);
    check(!grant_valid, "R9 reset valid", int'(grant_valid), 0);
    check(grant_num == 0, "R9 reset num", int'(grant_num), 0);
    rst_n = 1'b1;
    tick(3);

    cur_req = "R7";
    chan_irq[5] = 1'b1;
    tick(2);
    check(!grant_valid, "R7 not yet", int'(grant_valid), 0);
    tick(1);
    check(grant_valid && grant_num == 5, "R7 third edge", int'(grant_num), 5);

    cur_req = "R8";
    tick(5);
    check(grant_valid && grant_num == 5, "R8 hold", int'(grant_num), 5);

    cur_req = "R1";
    chan_irq[10] = 1'b1;
    tick(3);
    check(grant_num == 10, "R1 preempt", int'(grant_num), 10);

    cur_req = "R4";
    grant_ready = 1'b1;
    tick(1);
    grant_ready = 1'b0;
    check(grant_valid && grant_num == 5, "R4 other kept", int'(grant_num), 5);

    cur_req = "R2";
    tick(4);
    check(grant_num == 5, "R2 held line no rerequest", int'(grant_num), 5);

    cur_req = "R3";
    chan_irq[5] = 1'b0;
    tick(2);
    check(grant_valid, "R3 still shown", int'(grant_valid), 1);
    tick(1);
    check(!grant_valid, "R3 withdrawn", int'(grant_valid), 0);
    check(grant_num == 0, "R6 idle num", int'(grant_num), 0);

    cur_req = "R2";
    chan_irq[10] = 1'b0;
    tick(4);
    chan_irq[10] = 1'b1;
    tick(3);
    check(grant_valid && grant_num == 10, "R2 rearmed", int'(grant_num), 10);
    grant_ready = 1'b1;
    tick(1);
    grant_ready = 1'b0;
    check(!grant_valid, "R6 empty after transfer", int'(grant_valid), 0);
    chan_irq = '0;
    tick(4);

    cur_req = "R5";
    chan_irq = 16'h2107;
    tick(8);
    check(!grant_valid, "R5 board lines", int'(grant_valid), 0);
    chan_irq = '0;
    tick(4);

    cur_req = "R1";
    chan_irq = 16'hFFFF;
    tick(3);
    grant_ready = 1'b1;
    foreach (order[i]) begin
      check(grant_valid && grant_num == 4'(order[i]), "R1 drain order", int'(grant_num), order[i]);
      tick(1);
    end
    check(!grant_valid, "R6 drained", int'(grant_valid), 0);
    grant_ready = 1'b0;
    chan_irq = '0;
    tick(4);

    cur_req = "R1";
    for (int c = 0; c < 4000; c++) begin
      if ($urandom_range(0, 3) == 0) chan_irq[$urandom_range(0, 15)] ^= 1'b1;
      grant_ready = ($urandom_range(0, 2) == 0);
      tick(1);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule